// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block turns a parallel word into a serial bit stream inside a single-clock design. While the active-low load input is held low, the register keeps copying the parallel inputs. When load is high, it moves one place toward its last stage on every rising edge of a combined shift clock. The combined clock is the OR of a shift-clock pin and an active-low enable pin, so either pin can act as the clock while the other gates it. The last stage is driven out in true and in inverted form.

All three control pins are asynchronous to the system clock. Each one passes through a synchronizer of `SYNC_STAGES` flops. A rising edge of the synchronized OR produces a one-cycle shift strobe. Two copies can be chained by feeding the last-stage output of one into the serial input of the next. Both copies share the same control pins, and together they shift a word twice as long.

Top module: `par_serial_shreg`

## Requirements
- R1: Synchronous reset clears every stage to zero, so `ser_out` is 0 and `ser_out_n` is 1. The edge detector is preset high, so no shift takes place in the cycles that follow reset.
- R2: While `load_n` is low, the register copies `par_in` on every system cycle. `par_in[WIDTH-1]` is the last stage and appears on `ser_out`. `sclk`, `shift_en_n` and `ser_in` have no effect during this time.
- R3: While `load_n` is high, each rising edge of (`sclk` OR `shift_en_n`) shifts the register by exactly one place. `ser_in` enters stage 0, and stage n moves to stage n+1.
- R4: While `shift_en_n` is high, toggling `sclk` causes no shift and the contents are held.
- R5: With `sclk` held low, a low-then-high pulse on `shift_en_n` shifts the register once. This makes the two pins interchangeable as clock and enable.
- R6: `ser_out_n` is always the inverse of `ser_out`.
- R7: A combined-clock rising edge that occurs while load is active is discarded. If load is released while the combined clock is low, nothing shifts until the next rising edge.
- R8: With the default of 2 synchronizer stages, a pin change driven just after a system edge reaches the register on the third system edge that follows.
- R9: Two instances chained output-to-serial-input form a 2*WIDTH shifter. The instance at the end of the chain emits the combined word, most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Parallel load, active low, asynchronous pin |
| par_in | input | WIDTH | Parallel data; bit WIDTH-1 maps to the last stage |
| ser_in | input | 1 | Serial data into stage 0 |
| sclk | input | 1 | Shift clock pin, asynchronous |
| shift_en_n | input | 1 | Shift enable, active low, ORed with sclk |
| ser_out | output | 1 | Last stage |
| ser_out_n | output | 1 | Inverse of the last stage |

## Verification
The hardest situations to reach from the ports are the ones where the combined clock rises at a moment it should be ignored. One case is a rising edge while load is active. The other is releasing load while the combined clock is low. In both cases the only visible trace of a wrong shift is a stage that has not yet reached the output. To expose it, the stimulus loads a word whose last two bits differ and then applies a single shift. A discarded edge and a leaked edge then leave different values on `ser_out`. The enable pin is also driven as the clock, with `sclk` held low. Across all 256 loaded values, the inputs are stepped at least three system cycles apart so that the synchronizer latency is settled before every comparison.

// File: rtl/piso_pkg.sv
package piso_pkg;
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_LOAD  = 2'd1,
      OP_SHIFT = 2'd2
   } piso_op_e;
endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] ff;
         always_ff @(posedge clk) begin
            if (rst) begin
               ff <= {STAGES{RST_VAL}};
            end else begin
               ff[0] <= d;
               for (int i = 1; i < STAGES; i++) ff[i] <= ff[i-1];
            end
         end
         assign q = ff[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pss_edge.sv
module pss_edge (
   input  logic clk,
   input  logic rst,
   input  logic lvl,
   output logic rise
);
   logic prev;
   always_ff @(posedge clk) begin
      if (rst) prev <= 1'b1;
      else     prev <= lvl;
   end
   assign rise = lvl & ~prev;
endmodule

// File: rtl/pss_core.sv
module pss_core
   import piso_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  piso_op_e         op,
   input  logic [WIDTH-1:0] par_in,
   input  logic             ser_in,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else begin
         case (op)
            OP_LOAD:  q <= par_in;
            OP_SHIFT: q <= {q[WIDTH-2:0], ser_in};
            default:  q <= q;
         endcase
      end
   end
endmodule

// File: rtl/par_serial_shreg.sv
module par_serial_shreg
   import piso_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_n,
   input  logic [WIDTH-1:0] par_in,
   input  logic             ser_in,
   input  logic             sclk,
   input  logic             shift_en_n,
   output logic             ser_out,
   output logic             ser_out_n
);
   localparam int unsigned LAST = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_width_bad
         $error("par_serial_shreg: WIDTH must be at least 2");
      end
      if (SYNC_STAGES > 4) begin : g_sync_bad
         $error("par_serial_shreg: SYNC_STAGES above 4 is not supported");
      end
   endgenerate

   logic load_s, sclk_s, en_n_s, comb_clk, shift_fire;
   piso_op_e op;
   logic [WIDTH-1:0] q_reg;

   pss_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_load (
      .clk(clk), .rst(rst), .d(load_n), .q(load_s));
   pss_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sclk (
      .clk(clk), .rst(rst), .d(sclk), .q(sclk_s));
   pss_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_en (
      .clk(clk), .rst(rst), .d(shift_en_n), .q(en_n_s));

   // Gated clock: either pin high blocks the edge of the other.
   assign comb_clk = sclk_s | en_n_s;

   pss_edge u_edge (.clk(clk), .rst(rst), .lvl(comb_clk), .rise(shift_fire));

   // Load is a level override: an edge in a load cycle is dropped.
   always_comb begin
      if (!load_s)         op = OP_LOAD;
      else if (shift_fire) op = OP_SHIFT;
      else                 op = OP_HOLD;
   end

   pss_core #(.WIDTH(WIDTH)) u_core (
      .clk(clk), .rst(rst), .op(op), .par_in(par_in), .ser_in(ser_in), .q(q_reg));

   assign ser_out   = q_reg[LAST];
   assign ser_out_n = ~q_reg[LAST];
endmodule

// File: rtl/par_serial_shreg_chk.sv
module par_serial_shreg_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             load_s,
   input logic             en_n_s,
   input logic             shift_fire,
   input logic             ser_in,
   input logic [WIDTH-1:0] par_in,
   input logic [WIDTH-1:0] q_reg
);
   // R2
   load_follow_chk: assert property (@(posedge clk) disable iff (rst)
      !load_s |=> q_reg == $past(par_in));

   // R3
   shift_step_chk: assert property (@(posedge clk) disable iff (rst)
      (load_s && shift_fire) |=> q_reg == {$past(q_reg[WIDTH-2:0]), $past(ser_in)});

   // R4
   hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (load_s && !shift_fire) |=> $stable(q_reg));

   // R4
   enable_block_chk: assert property (@(posedge clk) disable iff (rst)
      (en_n_s && $past(en_n_s)) |-> !shift_fire);

   // R3
   single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      shift_fire |=> !shift_fire);
endmodule

bind par_serial_shreg par_serial_shreg_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst(rst), .load_s(load_s), .en_n_s(en_n_s),
   .shift_fire(shift_fire), .ser_in(ser_in), .par_in(par_in), .q_reg(q_reg));

// File: tb/par_serial_shreg_bench.sv
`timescale 1ns/1ps
module par_serial_shreg_bench;
   localparam int SETTLE = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic load_n = 1'b1;
   logic [7:0] par_a = '0;
   logic [7:0] par_b = '0;
   logic ser_in = 1'b0;
   logic sclk = 1'b1;
   logic shift_en_n = 1'b0;
   logic so_a, so_a_n, so_b, so_b_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [7:0]  exp_a;
   logic [15:0] exp_w;

   always #2 clk = ~clk;

   par_serial_shreg u_par_serial_shreg (
      .clk(clk), .rst(rst), .load_n(load_n), .par_in(par_a), .ser_in(ser_in),
      .sclk(sclk), .shift_en_n(shift_en_n), .ser_out(so_a), .ser_out_n(so_a_n));

   par_serial_shreg u_par_serial_shreg_tail (
      .clk(clk), .rst(rst), .load_n(load_n), .par_in(par_b), .ser_in(so_a),
      .sclk(sclk), .shift_en_n(shift_en_n), .ser_out(so_b), .ser_out_n(so_b_n));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // Checks the true output and its complement (R6).
   task automatic chk_out(input string req, input logic o, input logic o_n, input logic exp);
      chk(req, o, exp);
      chk("R6", o_n, ~exp);
   endtask

   task automatic do_load(input logic [7:0] a, input logic [7:0] b);
      load_n = 1'b0; par_a = a; par_b = b;
      tick(SETTLE);
   endtask

   task automatic release_load();
      sclk = 1'b1; tick(1);
      load_n = 1'b1; tick(SETTLE);
   endtask

   task automatic clk_pulse(input logic si);
      ser_in = si; sclk = 1'b0; tick(SETTLE);
      sclk = 1'b1; tick(SETTLE);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      ser_in = 1'b1;
      tick(3);
      rst = 1'b0;
      tick(SETTLE);
      // R1: cleared stages, no spurious shift after reset
      chk_out("R1", so_a, so_a_n, 1'b0);
      chk_out("R1", so_b, so_b_n, 1'b0);

      // R8: latency from sclk rise to register update
      do_load(8'h80, 8'h00);
      release_load();
      ser_in = 1'b0; sclk = 1'b0; tick(SETTLE);
      sclk = 1'b1;
      tick(2);
      chk_out("R8", so_a, so_a_n, 1'b1);
      tick(1);
      chk_out("R8", so_a, so_a_n, 1'b0);
      tick(SETTLE);

      // R2 / R3: sweep of every loaded value, shifted out fully
      for (int v = 0; v < 256; v++) begin
         do_load(v[7:0], ~v[7:0]);
         exp_a = v[7:0];
         chk_out("R2", so_a, so_a_n, exp_a[7]);
         release_load();
         for (int k = 0; k < 8; k++) begin
            logic si;
            si = ~v[k];
            exp_a = {exp_a[6:0], si};
            clk_pulse(si);
            chk_out("R3", so_a, so_a_n, exp_a[7]);
         end
      end

      // R2 / R7: load follows par_in; edges during load are discarded
      do_load(8'h00, 8'h00);
      chk_out("R2", so_a, so_a_n, 1'b0);
      par_a = 8'hFF; tick(SETTLE);
      chk_out("R2", so_a, so_a_n, 1'b1);
      ser_in = 1'b0; sclk = 1'b0; tick(SETTLE); sclk = 1'b1; tick(SETTLE);
      chk_out("R7", so_a, so_a_n, 1'b1);
      par_a = 8'h7F; tick(SETTLE);
      chk_out("R2", so_a, so_a_n, 1'b0);
      release_load();
      chk_out("R7", so_a, so_a_n, 1'b0);
      clk_pulse(1'b0);
      chk_out("R7", so_a, so_a_n, 1'b1);

      // R4: enable high blocks sclk
      do_load(8'hA5, 8'h00);
      release_load();
      shift_en_n = 1'b1; tick(SETTLE);
      for (int k = 0; k < 5; k++) clk_pulse(k[0]);
      chk_out("R4", so_a, so_a_n, 1'b1);
      shift_en_n = 1'b0; tick(SETTLE);
      chk_out("R4", so_a, so_a_n, 1'b1);
      clk_pulse(1'b0);
      chk_out("R4", so_a, so_a_n, 1'b0);

      // R5: enable used as clock with sclk low
      load_n = 1'b0; par_a = 8'h40; shift_en_n = 1'b1; tick(SETTLE);
      sclk = 1'b0; tick(SETTLE);
      load_n = 1'b1; tick(SETTLE);
      chk_out("R5", so_a, so_a_n, 1'b0);
      shift_en_n = 1'b0; tick(SETTLE);
      shift_en_n = 1'b1; tick(SETTLE);
      chk_out("R5", so_a, so_a_n, 1'b1);
      shift_en_n = 1'b0; tick(SETTLE);
      shift_en_n = 1'b1; tick(SETTLE);
      chk_out("R5", so_a, so_a_n, 1'b0);
      sclk = 1'b1; tick(1); shift_en_n = 1'b0; tick(SETTLE);

      // R7: release while combined clock is low, then one rise
      load_n = 1'b0; par_a = 8'h80; tick(SETTLE);
      sclk = 1'b0; tick(SETTLE);
      load_n = 1'b1; tick(SETTLE);
      chk_out("R7", so_a, so_a_n, 1'b1);
      ser_in = 1'b0; sclk = 1'b1; tick(SETTLE);
      chk_out("R7", so_a, so_a_n, 1'b0);

      // R9: 16-bit cascade, tail emits {tail, head} MSB first
      do_load(8'h3C, 8'hA5);
      release_load();
      exp_w = 16'hA53C;
      chk_out("R9", so_b, so_b_n, exp_w[15]);
      for (int k = 0; k < 16; k++) begin
         logic si;
         si = (k % 3) == 0;
         exp_w = {exp_w[14:0], si};
         clk_pulse(si);
         chk_out("R9", so_b, so_b_n, exp_w[15]);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule